// File: doc/BRIEF.md
# MAC Interrupt Status and Error Counter Unit

This block collects single-cycle event pulses from a network MAC's datapaths and turns them into one interrupt line. Receive completion, transmit completion and management-bus completion each latch a sticky status bit. Four 8-bit hardware counters count missed frames, CRC errors, framing errors and receive overflows. Each counter latches its own status bit only when it rolls over from 255 to 0. Software therefore adds 256 to its error totals for every such bit it sees.

Software reaches the block through a word-addressed register port. The port has a write strobe and a combinational read data bus. Status bits are cleared by writing ones to them. An enable register has one mask bit for receive, one for transmit and one for the whole error group. The interrupt line is the registered OR of every status bit that is both set and enabled. Management-bus completion has no mask bit and is meant to be polled. Writing a separate request bit in the status word sends a one-cycle pulse to the transmitter, asking it to rescan its descriptor ring. A read-only identification word returns a fixed revision value.

Top module: `mac_irq_unit`

## Requirements
- R1: Address 0 reads the identification constant `ID_VALUE` (default 0x0007fd02), and writes to it have no effect.
- R2: Pulses on the receive, transmit and management events set status bits 0, 1 and 2 (address 1) at the clock edge that samples them. The bits stay set until software clears them.
- R3: Writing the status word clears each of bits 0..6 written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event and a clear of the same status bit arrive in one cycle, the bit ends up set.
- R5: `err_evt_i` bit 0 (missed), 1 (CRC), 2 (framing) and 3 (overflow) each increment an 8-bit counter that wraps from 255 to 0. All four counters read from address 3 as bytes 0, 1, 2 and 3 in that order.
- R6: Status bits 3..6 belong to counters 0..3. Each one sets only at the event that wraps its counter, which is the 256th, and never before.
- R7: Writes to the counter word at address 3 leave all four counters unchanged.
- R8: Enable register (address 2) bit 0 masks status bit 0, bit 1 masks status bit 1, and bit 2 masks status bits 3..6 together. Status bit 2 never raises the interrupt. The register reads back only bits 2..0.
- R9: `irq_o` is high exactly one cycle after some status bit and its enable are both set, and falls one cycle after the last such pair clears.
- R10: Writing 1 to bit 8 of the status word gives a `tx_poll_o` pulse in the following cycle only. Bit 8 always reads 0.
- R11: After reset, status, enable and counters read 0 and `irq_o` and `tx_poll_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_evt_i | input | 1 | Receive-done event pulse |
| tx_evt_i | input | 1 | Transmit-done event pulse |
| mgmt_evt_i | input | 1 | Management-bus transfer complete pulse |
| err_evt_i | input | N_ERR (4) | Error event pulses: missed, CRC, framing, overflow |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (3) | Register word address |
| wdata_i | input | DATA_W (32) | Register write data |
| rdata_o | output | DATA_W (32) | Register read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request, registered |
| tx_poll_o | output | 1 | One-cycle request to rescan the transmit ring |

## Verification
The bench drives a counter through exactly 255 events and checks that its status bit is still clear. It then checks that the 256th event both returns the counter to zero and sets the bit. A design that wraps late, or flags on every event, fails there. An event is driven in the same cycle as a clear of its own bit, which exposes a design that gives the clear priority and loses the event. The interrupt is sampled in the cycle the status changes and again one cycle later, and each mask bit is tried in turn, including the management bit that must never raise the line. This catches a wrong mask routing or an unregistered or doubly registered output. Writes aimed at the counter word and at the request bit confirm that neither one stores state.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;

    localparam int unsigned N_ERR      = 4;
    localparam int unsigned STS_RX     = 0;
    localparam int unsigned STS_TX     = 1;
    localparam int unsigned STS_MGMT   = 2;
    localparam int unsigned STS_ERR_LO = 3;
    localparam int unsigned STS_W      = STS_ERR_LO + N_ERR;
    localparam int unsigned POLL_BIT   = 8;

    localparam int unsigned EN_RX  = 0;
    localparam int unsigned EN_TX  = 1;
    localparam int unsigned EN_ERR = 2;
    localparam int unsigned EN_W   = 3;

    localparam int unsigned A_ID   = 0;
    localparam int unsigned A_STS  = 1;
    localparam int unsigned A_EN   = 2;
    localparam int unsigned A_CNT  = 3;

    typedef struct packed {
        logic [EN_W-1:0] en;
        logic            poll;
        logic            irq;
    } ctl_t;

endpackage

// File: rtl/irq_evt_counter.sv
module irq_evt_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             evt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        wrap_o = 1'b0;
        if (evt_i) begin
            cnt_d  = cnt_q + CNT_W'(1);
            wrap_o = (cnt_q == {CNT_W{1'b1}});
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/irq_status_bits.sv
module irq_status_bits #(
    parameter int unsigned N = 7
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] sts_o
);
    logic [N-1:0] sts_d, sts_q;

    // set wins over a clear in the same cycle
    always_comb begin
        sts_d = (sts_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sts_q <= '0;
        else         sts_q <= sts_d;
    end

    assign sts_o = sts_q;
endmodule

// File: rtl/mac_irq_unit.sv
module mac_irq_unit
    import mac_irq_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 3,
    parameter int unsigned       DATA_W   = 32,
    parameter int unsigned       CNT_W    = 8,
    parameter logic [DATA_W-1:0] ID_VALUE = 'h0007fd02
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rx_evt_i,
    input  logic              tx_evt_i,
    input  logic              mgmt_evt_i,
    input  logic [N_ERR-1:0]  err_evt_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic              tx_poll_o
);
    localparam int unsigned CNT_ALL_W = N_ERR * CNT_W;

    logic [CNT_ALL_W-1:0] cnt_all;
    logic [N_ERR-1:0]     err_wrap;
    logic [STS_W-1:0]     sts_set, sts_clr, sts_q;
    logic [STS_W-1:0]     irq_mask;
    logic                 wr_sts;
    ctl_t                 ctl_d, ctl_q;
    logic                 unused_wdata;

    assign unused_wdata = ^wdata_i;

    for (genvar g = 0; g < N_ERR; g++) begin : g_cnt
        irq_evt_counter #(.CNT_W(CNT_W)) cnt_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .evt_i  (err_evt_i[g]),
            .cnt_o  (cnt_all[g*CNT_W +: CNT_W]),
            .wrap_o (err_wrap[g])
        );
    end

    assign wr_sts  = wr_en_i && (addr_i == ADDR_W'(A_STS));
    assign sts_set = {err_wrap, mgmt_evt_i, tx_evt_i, rx_evt_i};
    assign sts_clr = wr_sts ? wdata_i[STS_W-1:0] : '0;

    irq_status_bits #(.N(STS_W)) sts_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (sts_set),
        .clr_i  (sts_clr),
        .sts_o  (sts_q)
    );

    always_comb begin
        irq_mask                       = '0;
        irq_mask[STS_RX]               = ctl_q.en[EN_RX];
        irq_mask[STS_TX]               = ctl_q.en[EN_TX];
        irq_mask[STS_ERR_LO +: N_ERR]  = {N_ERR{ctl_q.en[EN_ERR]}};
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.poll = 1'b0;
        if (wr_en_i && (addr_i == ADDR_W'(A_EN))) begin
            ctl_d.en = wdata_i[EN_W-1:0];
        end
        if (wr_sts) begin
            ctl_d.poll = wdata_i[POLL_BIT];
        end
        ctl_d.irq = |(sts_q & irq_mask);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ctl_q <= '0;
        else         ctl_q <= ctl_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(A_ID):  rdata_o = ID_VALUE;
            ADDR_W'(A_STS): rdata_o[STS_W-1:0] = sts_q;
            ADDR_W'(A_EN):  rdata_o[EN_W-1:0] = ctl_q.en;
            ADDR_W'(A_CNT): rdata_o[CNT_ALL_W-1:0] = cnt_all;
            default:        rdata_o = '0;
        endcase
    end

    assign irq_o     = ctl_q.irq;
    assign tx_poll_o = ctl_q.poll;
endmodule

// File: rtl/mac_irq_unit_chk.sv
module mac_irq_unit_chk
    import mac_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 8
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   rx_evt_i,
    input logic [N_ERR-1:0]       err_evt_i,
    input logic                   wr_en_i,
    input logic [ADDR_W-1:0]      addr_i,
    input logic [DATA_W-1:0]      wdata_i,
    input logic [STS_W-1:0]       sts_q,
    input logic [EN_W-1:0]        en_q,
    input logic [N_ERR*CNT_W-1:0] cnt_all,
    input logic                   irq_o,
    input logic                   tx_poll_o
);
    logic             wr_sts;
    logic [STS_W-1:0] clr_vec;
    logic [STS_W-1:0] live;
    logic             unused_wdata;

    assign unused_wdata = ^wdata_i;
    assign wr_sts  = wr_en_i && (addr_i == ADDR_W'(A_STS));
    assign clr_vec = wr_sts ? wdata_i[STS_W-1:0] : '0;
    assign live    = sts_q & { {N_ERR{en_q[EN_ERR]}}, 1'b0, en_q[EN_TX], en_q[EN_RX] };

    // R2: a set bit drops only when a clear for it was written
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((($past(sts_q) & ~$past(clr_vec)) & ~sts_q) == '0));

    // R3: clearing the receive bit without a new event empties it
    p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_sts && wdata_i[STS_RX] && !rx_evt_i) |=> !sts_q[STS_RX]);

    // R4: event beats a clear in the same cycle
    p_race_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_sts && wdata_i[STS_RX] && rx_evt_i) |=> sts_q[STS_RX]);

    // R6: missed-frame bit rises only on the wrapping event
    p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sts_q[STS_ERR_LO]) |->
            ($past(err_evt_i[0]) && ($past(cnt_all[CNT_W-1:0]) == {CNT_W{1'b1}})));

    // R8: the management bit alone never raises the interrupt
    p_mgmt_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sts_q & ~(STS_W'(1) << STS_MGMT)) == '0) |=> !irq_o);

    // R9: interrupt is the registered OR of live bits
    p_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (irq_o == $past(|live)));

    // R10: poll pulse follows the write by one cycle
    p_poll_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (tx_poll_o == $past(wr_sts && wdata_i[POLL_BIT])));
endmodule

bind mac_irq_unit mac_irq_unit_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_evt_i  (rx_evt_i),
    .err_evt_i (err_evt_i),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .sts_q     (sts_q),
    .en_q      (ctl_q.en),
    .cnt_all   (cnt_all),
    .irq_o     (irq_o),
    .tx_poll_o (tx_poll_o)
);

// File: tb/mac_irq_unit_tb_top.sv
module mac_irq_unit_tb_top;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned DATA_W = 32;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              rx_evt_i = 1'b0, tx_evt_i = 1'b0, mgmt_evt_i = 1'b0;
    logic [3:0]        err_evt_i = '0;
    logic              wr_en_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DATA_W-1:0] wdata_i = '0;
    logic [DATA_W-1:0] rdata_o;
    logic              irq_o, tx_poll_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk_i = ~clk_i;

    mac_irq_unit dut_i (
        .clk_i, .rst_ni, .rx_evt_i, .tx_evt_i, .mgmt_evt_i, .err_evt_i,
        .wr_en_i, .addr_i, .wdata_i, .rdata_o, .irq_o, .tx_poll_o
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        @(negedge clk_i);
        wr_en_i = 1'b1; addr_i = ADDR_W'(a); wdata_i = d;
        @(negedge clk_i);
        wr_en_i = 1'b0; wdata_i = '0;
    endtask

    task automatic do_read(input int a, output logic [31:0] d);
        addr_i = ADDR_W'(a);
        #1;
        d = rdata_o;
    endtask

    // vec: {err[3:0], mgmt, tx, rx}
    task automatic pulse(input logic [6:0] vec);
        @(negedge clk_i);
        {err_evt_i, mgmt_evt_i, tx_evt_i, rx_evt_i} = vec;
        @(negedge clk_i);
        {err_evt_i, mgmt_evt_i, tx_evt_i, rx_evt_i} = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        do_read(0, v); check("R1 id", v, 32'h0007fd02);
        do_write(0, 32'h0);
        do_read(0, v); check("R1 id after write", v, 32'h0007fd02);
        do_read(1, v); check("R11 status", v, 0);
        do_read(2, v); check("R11 enable", v, 0);
        do_read(3, v); check("R11 counters", v, 0);
        check("R11 irq", {31'b0, irq_o}, 0);
        check("R11 poll", {31'b0, tx_poll_o}, 0);
    endtask

    task automatic t_sticky_clear;
        logic [31:0] v;
        pulse(7'b0000001);
        pulse(7'b0000010);
        pulse(7'b0000100);
        repeat (3) @(negedge clk_i);
        do_read(1, v); check("R2 sticky", v, 32'h7);
        do_write(1, 32'h0);
        do_read(1, v); check("R3 write zero", v, 32'h7);
        do_write(1, 32'h2);
        do_read(1, v); check("R3 clear tx", v, 32'h5);
        do_write(1, 32'h5);
        do_read(1, v); check("R3 clear rest", v, 32'h0);
    endtask

    task automatic t_race;
        logic [31:0] v;
        pulse(7'b0000001);
        @(negedge clk_i);
        rx_evt_i = 1'b1; wr_en_i = 1'b1; addr_i = ADDR_W'(1); wdata_i = 32'h1;
        @(negedge clk_i);
        rx_evt_i = 1'b0; wr_en_i = 1'b0; wdata_i = '0;
        do_read(1, v); check("R4 event beats clear", v, 32'h1);
        do_write(1, 32'h1);
        do_read(1, v); check("R3 clear after race", v, 32'h0);
    endtask

    task automatic t_counters;
        logic [31:0] v;
        for (int i = 0; i < 20; i++) begin
            pulse({(i < 20), (i < 10), (i < 3), 4'b0000});
        end
        for (int i = 0; i < 255; i++) pulse(7'b0001000);
        do_read(3, v); check("R5 counts", v, 32'h140A03FF);
        do_read(1, v); check("R6 no early flag", v, 32'h0);
        pulse(7'b0001000);
        do_read(3, v); check("R5 wrap to zero", v, 32'h140A0300);
        do_read(1, v); check("R6 missed flag", v, 32'h8);
        do_write(3, 32'hFFFFFFFF);
        do_read(3, v); check("R7 counters not writable", v, 32'h140A0300);
        do_write(1, 32'h7F);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        do_write(2, 32'hFFFFFFFF);
        do_read(2, v); check("R8 enable readback", v, 32'h7);
        do_write(2, 32'h0);
        pulse(7'b0000001);
        repeat (2) @(negedge clk_i);
        check("R8 rx masked", {31'b0, irq_o}, 0);
        do_write(2, 32'h1);
        check("R9 irq not yet", {31'b0, irq_o}, 0);
        @(negedge clk_i);
        check("R9 irq rx", {31'b0, irq_o}, 1);
        do_write(1, 32'h1);
        @(negedge clk_i);
        check("R9 irq drops", {31'b0, irq_o}, 0);
        do_write(2, 32'h2);
        pulse(7'b0000010);
        check("R9 irq one cycle later", {31'b0, irq_o}, 0);
        @(negedge clk_i);
        check("R8 tx enabled", {31'b0, irq_o}, 1);
        do_write(1, 32'h2);
        do_write(2, 32'h7);
        pulse(7'b0000100);
        repeat (2) @(negedge clk_i);
        check("R8 mgmt never interrupts", {31'b0, irq_o}, 0);
        do_write(2, 32'h3);
        for (int i = 0; i < 236; i++) pulse(7'b1000000);
        do_read(1, v); check("R6 overflow flag", v, 32'h44);
        do_read(3, v); check("R5 overflow wrap", v, 32'h000A0300);
        repeat (2) @(negedge clk_i);
        check("R8 error group masked", {31'b0, irq_o}, 0);
        do_write(2, 32'h4);
        @(negedge clk_i);
        check("R8 error group enabled", {31'b0, irq_o}, 1);
        do_write(1, 32'h7F);
        @(negedge clk_i);
        check("R9 irq clear", {31'b0, irq_o}, 0);
    endtask

    task automatic t_poll;
        logic [31:0] v;
        pulse(7'b0000001);
        check("R10 idle", {31'b0, tx_poll_o}, 0);
        do_write(1, 32'h100);
        check("R10 pulse", {31'b0, tx_poll_o}, 1);
        @(negedge clk_i);
        check("R10 single cycle", {31'b0, tx_poll_o}, 0);
        do_read(1, v); check("R10 bit reads zero, status kept", v, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_sticky_clear();
        t_race();
        t_counters();
        t_irq();
        t_poll();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule